// File: doc/BRIEF.md
# SIMD Widening Shift-Left Unit

This datapath executes the unsigned widening left-shift-by-immediate vector operation. It takes a 32-bit instruction word, a 128-bit source vector and an input valid strobe. It decodes the word and chooses a 64-bit half of the source. Each lane of that half is zero-extended to twice its width, shifted left by an immediate amount, and truncated to the doubled width. The widened lanes fill the 128-bit result.

A single 7-bit immediate carries two values. The position of its highest set bit fixes the lane width, and the remainder above that width is the shift. The unit flags two cases. One is an encoding whose lane-size field is out of range, which is undefined. The other is a shift of zero, where the operation reduces to a plain zero extension and the extension alias is preferred. The result path is one register stage, so latency never depends on the data.

Top module: `widen_shl_unit`

## Requirements
- R1: A word is accepted only when bit 31 is 0, bits 29..23 equal 1011110, bits 15..10 equal 101001 and bits 22..19 (the size field) are not 0000. Any other word gives out_valid=0, out_undef=0, out_alias=0 and out_result=0 one cycle later.
- R2: An accepted word with bit 22 set gives out_undef=1, out_valid=0, out_alias=0 and out_result=0 one cycle later.
- R3: The lane width is 32 when bit 21 is set, otherwise 16 when bit 20 is set, otherwise 8.
- R4: The shift amount is the 7-bit value of bits 22..16 minus the lane width, and it always lies in 0 to width-1.
- R5: Bit 30 selects the source half: 0 takes bits 63..0 and 1 takes bits 127..64.
- R6: Source lane e (lane 0 at the least significant bits) is zero-extended to twice its width, shifted left and truncated, and lands in result lane e. The 64/width result lanes fill all 128 bits.
- R7: out_alias is 1, together with out_valid, exactly when the result is valid, bits 18..16 are 000 and bits 22..19 have exactly one bit set.
- R8: The outputs appear exactly one clock after the input is sampled. When in_valid is 0, out_valid, out_undef, out_alias and out_result are all 0 one cycle later.
- R9: An active-low synchronous reset clears out_valid, out_undef, out_alias and out_result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Instruction and operand valid |
| instr | input | 32 | Instruction word |
| src_vec | input | 128 | Source vector value |
| out_valid | output | 1 | Result valid |
| out_undef | output | 1 | Undefined encoding flag |
| out_alias | output | 1 | Zero-extension alias preferred |
| out_result | output | 128 | Widened, shifted result |

## Verification
The bench sweeps every combination of the 4-bit size field and the 3-bit shift field. Each combination is run with both half selections and four data patterns. All-ones data exposes truncation and wrong shift amounts. A byte-ramp pattern tells lanes and halves apart, and it catches a lane that is swapped or taken from the wrong half. Alternating and sparse patterns catch errors in the zero extension. Words with a single fixed opcode bit flipped check that the decode rejects near misses. Cycles with in_valid low, and a reset taken in the middle of traffic, check that no stale result leaks out.

// File: rtl/widen_shl_pkg.sv
package widen_shl_pkg;
  localparam int INSTR_W = 32;
  localparam int VEC_W   = 128;
  localparam int HALF_W  = VEC_W / 2;
  localparam int SH_W    = 6;
  localparam int CODE_W  = 7;
  localparam int N_SIZES = 3;

  localparam logic [INSTR_W-1:0] FIX_MASK  = 32'hBF80FC00;
  localparam logic [INSTR_W-1:0] FIX_VALUE = 32'h2F00A400;

  typedef enum logic [1:0] {
    LANE_8  = 2'd0,
    LANE_16 = 2'd1,
    LANE_32 = 2'd2
  } lane_sz_e;

  typedef struct packed {
    logic             hit;
    logic             undef;
    logic             upper;
    lane_sz_e         sz;
    logic [SH_W-1:0]  shamt;
    logic             extend_only;
  } wsl_dec_t;

  function automatic logic f_opcode_hit(input logic [INSTR_W-1:0] w);
    return ((w & FIX_MASK) == FIX_VALUE) && (w[22:19] != 4'b0000);
  endfunction

  function automatic lane_sz_e f_lane_sz(input logic [2:0] sz_lo);
    if (sz_lo[2])      return LANE_32;
    else if (sz_lo[1]) return LANE_16;
    else               return LANE_8;
  endfunction

  function automatic logic [CODE_W-1:0] f_lane_bits(input lane_sz_e sz);
    return CODE_W'(8) << sz;
  endfunction

  function automatic logic [SH_W-1:0] f_shamt(input logic [CODE_W-1:0] code,
                                               input lane_sz_e sz);
    logic [CODE_W-1:0] diff;
    diff = code - f_lane_bits(sz);
    return diff[SH_W-1:0];
  endfunction

  function automatic logic f_extend_only(input logic [3:0] sz_fld,
                                         input logic [2:0] sh_fld);
    return (sh_fld == 3'b000) && ($countones(sz_fld) == 1);
  endfunction
endpackage

// File: rtl/wsl_decode.sv
module wsl_decode
  import widen_shl_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output wsl_dec_t           dec_o
);
  logic [3:0]        sz_fld;
  logic [2:0]        sh_fld;
  logic [CODE_W-1:0] code;
  lane_sz_e          sz;

  assign sz_fld = instr_i[22:19];
  assign sh_fld = instr_i[18:16];
  assign code   = instr_i[22:16];
  assign sz     = f_lane_sz(sz_fld[2:0]);

  always_comb begin
    dec_o             = '0;
    dec_o.hit         = f_opcode_hit(instr_i);
    dec_o.undef       = sz_fld[3];
    dec_o.upper       = instr_i[30];
    dec_o.sz          = sz;
    dec_o.shamt       = sz_fld[3] ? '0 : f_shamt(code, sz);
    dec_o.extend_only = f_extend_only(sz_fld, sh_fld);
  end
endmodule

// File: rtl/wsl_lane_array.sv
module wsl_lane_array #(
  parameter int HALF_W = 64,
  parameter int LANE_W = 8,
  parameter int SH_W   = 6
) (
  input  logic [HALF_W-1:0]   half_i,
  input  logic [SH_W-1:0]     shamt_i,
  output logic [2*HALF_W-1:0] wide_o
);
  localparam int LANES  = HALF_W / LANE_W;
  localparam int WIDE_W = 2 * LANE_W;

  for (genvar e = 0; e < LANES; e++) begin : g_lane
    logic [WIDE_W-1:0] ext;
    assign ext = {{LANE_W{1'b0}}, half_i[e*LANE_W +: LANE_W]};
    assign wide_o[e*WIDE_W +: WIDE_W] = ext << shamt_i;
  end
endmodule

// File: rtl/wsl_out_stage.sv
module wsl_out_stage #(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             d_valid,
  input  logic             d_undef,
  input  logic             d_alias,
  input  logic [VEC_W-1:0] d_result,
  output logic             q_valid,
  output logic             q_undef,
  output logic             q_alias,
  output logic [VEC_W-1:0] q_result
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid  <= 1'b0;
      q_undef  <= 1'b0;
      q_alias  <= 1'b0;
      q_result <= '0;
    end else begin
      q_valid  <= d_valid;
      q_undef  <= d_undef;
      q_alias  <= d_alias;
      q_result <= d_result;
    end
  end
endmodule

// File: rtl/widen_shl_unit.sv
module widen_shl_unit
  import widen_shl_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [31:0]  instr,
  input  logic [127:0] src_vec,
  output logic         out_valid,
  output logic         out_undef,
  output logic         out_alias,
  output logic [127:0] out_result
);
  wsl_dec_t          dec;
  logic [HALF_W-1:0] half_sel;
  logic [VEC_W-1:0]  size_res [N_SIZES];
  logic [VEC_W-1:0]  chosen_res;

  logic              fire_ok;
  logic              fire_undef;
  logic              dec_hit;
  logic              dec_undef;
  logic [SH_W-1:0]   dec_shamt;
  logic [CODE_W-1:0] dec_lane_bits;

  wsl_decode u_dec (
    .instr_i (instr),
    .dec_o   (dec)
  );

  assign half_sel = dec.upper ? src_vec[VEC_W-1:HALF_W] : src_vec[HALF_W-1:0];

  for (genvar g = 0; g < N_SIZES; g++) begin : g_size
    wsl_lane_array #(
      .HALF_W (HALF_W),
      .LANE_W (8 << g),
      .SH_W   (SH_W)
    ) u_lanes (
      .half_i  (half_sel),
      .shamt_i (dec.shamt),
      .wide_o  (size_res[g])
    );
  end

  always_comb begin
    case (dec.sz)
      LANE_16: chosen_res = size_res[1];
      LANE_32: chosen_res = size_res[2];
      default: chosen_res = size_res[0];
    endcase
  end

  assign dec_hit       = dec.hit;
  assign dec_undef     = dec.undef;
  assign dec_shamt     = dec.shamt;
  assign dec_lane_bits = f_lane_bits(dec.sz);
  assign fire_ok       = in_valid && dec.hit && !dec.undef;
  assign fire_undef    = in_valid && dec.hit && dec.undef;

  wsl_out_stage #(.VEC_W(VEC_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .d_valid  (fire_ok),
    .d_undef  (fire_undef),
    .d_alias  (fire_ok && dec.extend_only),
    .d_result (fire_ok ? chosen_res : '0),
    .q_valid  (out_valid),
    .q_undef  (out_undef),
    .q_alias  (out_alias),
    .q_result (out_result)
  );
endmodule

// File: rtl/widen_shl_chk.sv
module widen_shl_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [31:0]  instr,
  input logic         out_valid,
  input logic         out_undef,
  input logic         out_alias,
  input logic [127:0] out_result,
  input logic         dec_hit,
  input logic         dec_undef,
  input logic [5:0]   dec_shamt,
  input logic [6:0]   dec_lane_bits
);
  p_valid_needs_input_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  p_undef_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_undef |-> (!out_valid && !out_alias && out_result == '0));

  p_undef_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_undef |-> $past(in_valid && instr[22]));

  p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_result == '0 && !out_alias));

  p_lane_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_hit && !dec_undef) |-> ($countones(dec_lane_bits) == 1 && dec_lane_bits >= 7'd8
                                 && dec_lane_bits <= 7'd32));

  p_shamt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_hit && !dec_undef) |-> ({1'b0, dec_shamt} < dec_lane_bits));

  p_alias_seen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec_hit && !instr[22] && instr[18:16] == 3'b000
     && $onehot(instr[22:19])) |=> (out_alias && out_valid));

  p_alias_needs_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_alias |-> out_valid);
endmodule

bind widen_shl_unit widen_shl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .instr         (instr),
  .out_valid     (out_valid),
  .out_undef     (out_undef),
  .out_alias     (out_alias),
  .out_result    (out_result),
  .dec_hit       (dec_hit),
  .dec_undef     (dec_undef),
  .dec_shamt     (dec_shamt),
  .dec_lane_bits (dec_lane_bits)
);

// File: tb/widen_shl_unit_tb.sv
module widen_shl_unit_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [31:0]  instr = '0;
  logic [127:0] src_vec = '0;
  logic         out_valid, out_undef, out_alias;
  logic [127:0] out_result;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  widen_shl_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr), .src_vec(src_vec),
    .out_valid(out_valid), .out_undef(out_undef), .out_alias(out_alias),
    .out_result(out_result)
  );

  function automatic logic [31:0] mk_word(input logic q, input logic [3:0] szf,
                                          input logic [2:0] shf, input logic [4:0] rn,
                                          input logic [4:0] rd);
    return {1'b0, q, 7'b1011110, szf, shf, 6'b101001, rn, rd};
  endfunction

  function automatic logic [127:0] pattern(input int p);
    case (p)
      0: return {128{1'b1}};
      1: return 128'hFFEEDDCCBBAA99887766554433221100;
      2: return {32{4'hA}} ^ 128'h0F0F0000FFFF00000000FFFF0000F0F0;
      default: return 128'h80000001_00008001_00800001_80018001;
    endcase
  endfunction

  task automatic model(input logic r, input logic v, input logic [31:0] w,
                       input logic [127:0] src, output logic ev, output logic eu,
                       output logic ea, output logic [127:0] er);
    logic hit;
    int code, lw, sh;
    logic [63:0] half, lane;
    ev = 0; eu = 0; ea = 0; er = '0;
    hit = (w[31] == 1'b0) && (w[29:23] == 7'b1011110) && (w[15:10] == 6'b101001)
          && (w[22:19] != 4'd0);
    if (r && v && hit) begin
      if (w[22]) eu = 1;
      else begin
        code = int'(w[22:16]);
        lw = 8;
        while (lw * 2 <= code) lw = lw * 2;
        sh = code - lw;
        half = w[30] ? src[127:64] : src[63:0];
        ev = 1;
        for (int e = 0; e < 64 / lw; e++) begin
          lane = (half >> (e * lw)) & ((64'd1 << lw) - 64'd1);
          lane = lane << sh;
          if (lw < 32) lane = lane & ((64'd1 << (2 * lw)) - 64'd1);
          er = er | ({64'd0, lane} << (e * 2 * lw));
        end
        ea = (sh == 0) && ($countones(w[22:19]) == 1);
      end
    end
  endtask

  task automatic step(input logic r, input logic v, input logic [31:0] w,
                      input logic [127:0] src, input string tag);
    logic ev, eu, ea;
    logic [127:0] er;
    rst_n = r; in_valid = v; instr = w; src_vec = src;
    model(r, v, w, src, ev, eu, ea, er);
    @(negedge clk);
    checks++;
    if (out_valid !== ev || out_undef !== eu || out_alias !== ea || out_result !== er) begin
      failures++;
      $display("FAIL %s word=%h: got v=%0b u=%0b a=%0b r=%h exp v=%0b u=%0b a=%0b r=%h",
               tag, w, out_valid, out_undef, out_alias, out_result, ev, eu, ea, er);
    end
  endtask

  initial begin
    logic [31:0] base;
    @(negedge clk);
    // R9: reset holds outputs clear despite a valid input
    step(1'b0, 1'b1, mk_word(1'b0, 4'b0001, 3'd3, 5'd1, 5'd2), pattern(0), "R9");
    step(1'b0, 1'b1, mk_word(1'b1, 4'b0010, 3'd0, 5'd1, 5'd2), pattern(1), "R9");

    // R3/R4/R5/R6/R7 sweep, R2 for size field bit 3, R1 for zero size field
    for (int szf = 0; szf < 16; szf++)
      for (int shf = 0; shf < 8; shf++)
        for (int q = 0; q < 2; q++)
          for (int p = 0; p < 4; p++) begin
            string tg;
            if (szf == 0) tg = "R1";
            else if (szf >= 8) tg = "R2";
            else tg = "R3/R4/R5/R6/R7";
            step(1'b1, 1'b1, mk_word(q[0], szf[3:0], shf[2:0], 5'(p), 5'(szf)),
                 pattern(p), tg);
          end

    // R1: single-bit flips of fixed opcode bits
    base = mk_word(1'b0, 4'b0011, 3'd5, 5'd7, 5'd9);
    for (int b = 0; b < 32; b++)
      if (b == 31 || (b >= 23 && b <= 29) || (b >= 10 && b <= 15))
        step(1'b1, 1'b1, base ^ (32'd1 << b), pattern(1), "R1");

    // R8: in_valid low suppresses everything, then back-to-back traffic
    step(1'b1, 1'b1, mk_word(1'b1, 4'b0100, 3'd0, 5'd0, 5'd0), pattern(1), "R8");
    step(1'b1, 1'b0, mk_word(1'b1, 4'b0100, 3'd0, 5'd0, 5'd0), pattern(1), "R8");
    step(1'b1, 1'b1, mk_word(1'b0, 4'b0101, 3'd7, 5'd0, 5'd0), pattern(0), "R8");
    step(1'b1, 1'b0, mk_word(1'b0, 4'b1000, 3'd0, 5'd0, 5'd0), pattern(0), "R8");

    // R9: reset in the middle of traffic
    step(1'b1, 1'b1, mk_word(1'b0, 4'b0001, 3'd1, 5'd0, 5'd0), pattern(0), "R9");
    step(1'b0, 1'b1, mk_word(1'b0, 4'b0001, 3'd1, 5'd0, 5'd0), pattern(0), "R9");
    step(1'b1, 1'b1, mk_word(1'b1, 4'b0001, 3'd0, 5'd0, 5'd0), pattern(3), "R7");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule